// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This unit is the multiplier datapath of a small fixed-point signal processor. It holds a 40-bit product register and two 40-bit accumulators. On each clock where a command is presented, it multiplies two signed 16-bit operands. Depending on the command, it either replaces the product register with that product or adds the product to it or subtracts the product from it. Three commands also move the previous product into an accumulator on their way through. One copies it unchanged, one rounds it to a 16-bit boundary, and one adds it to the accumulator. In the same cycle the fresh product replaces the old one.

Status flags belong only to the accumulator path. The three commands that write an accumulator update carry, overflow, zero, negative, extension and unnormalized from the value they write. The three pure multiply commands leave every flag as it was. The unit sits behind an instruction decoder and a register file, which supply the command code, the operands and the accumulator select.

Top module: `dsp_mac_unit`

## Requirements
- R1: While reset is active, and after reset until the first command, the product register, both accumulators and all six flags read zero.
- R2: Command code 0 (plain multiply) loads the product register with the signed 16x16 product, sign-extended to 40 bits. Accumulators and flags are unchanged.
- R3: Command code 1 (accumulate) sets the product register to its previous value plus the new signed product, truncated to 40 bits.
- R4: Command code 2 (negative accumulate) sets the product register to its previous value minus the new signed product, truncated to 40 bits.
- R5: Command code 3 (move) writes the previous product into the selected accumulator, loads the new product, and clears carry and overflow.
- R6: Command code 4 (round) adds 0x8000 to the previous product and clears bits 15:0 of the sum before writing it to the selected accumulator. The added term is 0 instead when bits 15:0 equal 0x8000 and bit 16 is 0 (ties go to even). The new product is loaded in the same cycle.
- R7: Command code 5 (add) writes the selected accumulator plus the previous product back to that accumulator and loads the new product. Carry is the carry out of bit 39 of the unsigned 40-bit sum. Overflow is set when both addends have the same bit 39 and the sum's bit 39 differs from it. Round (R6) derives carry and overflow the same way from its addition.
- R8: For codes 3, 4 and 5, the remaining flags follow the written value. Zero is set when it is all zeros, and negative equals its bit 39. Extension is set when bits 39:31 are not all equal. Unnormalized is set when bit 31 equals bit 30.
- R9: Codes 0, 1 and 2 leave all six flags unchanged.
- R10: With the command valid low, or with code 6 or 7, no register or flag changes.
- R11: Accumulator select 0 picks accumulator A and 1 picks accumulator B. The accumulator not selected is never changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | Command code 0..5; 6 and 7 do nothing |
| op_dst | input | 1 | Accumulator select, 0 = A, 1 = B |
| opnd_x | input | 16 | Signed multiplicand |
| opnd_y | input | 16 | Signed multiplier |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| prod | output | 40 | Product register |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_e | output | 1 | Extension |
| flag_u | output | 1 | Unnormalized |

## Verification
The embedded properties check the following on every cycle:
- Idle and illegal commands freeze all state.
- Pure multiply commands hold the flags.
- The move command clears carry and overflow.
- The unselected accumulator is preserved.
- Rounding leaves the low 16 bits zero.
- Accumulate adds exactly the multiplier's output.
- The zero and negative flags agree with the accumulator just written.

Only the bench's scenarios show the remaining behaviour:
- the arithmetic values themselves,
- the tie-to-even choice between the two rounding cases,
- a genuine 40-bit signed overflow reached by a long accumulation run,
- the asynchronous clearing of state by a reset in the middle of a run.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  localparam int ACC_W  = 40;
  localparam int OPND_W = 16;
  localparam int RND_W  = 16;

  typedef enum logic [2:0] {
    OP_MPY   = 3'd0,
    OP_MAC   = 3'd1,
    OP_MACN  = 3'd2,
    OP_MVMPY = 3'd3,
    OP_RNMPY = 3'd4,
    OP_ADMPY = 3'd5
  } mac_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
    logic e;
    logic u;
  } mac_flags_t;
endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsp_mul.sv
module dsp_mul #(
  parameter int OPND_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [OPND_W-1:0] mul_x,
  input  logic [OPND_W-1:0] mul_y,
  output logic [ACC_W-1:0]  mul_p
);
  localparam int PW = 2 * OPND_W;

  logic signed [PW-1:0] full_p;
  assign full_p = $signed(mul_x) * $signed(mul_y);

  generate
    if (ACC_W > PW) begin : g_ext
      assign mul_p = {{(ACC_W-PW){full_p[PW-1]}}, full_p};
    end else if (ACC_W == PW) begin : g_same
      assign mul_p = full_p;
    end else begin : g_trunc
      assign mul_p = full_p[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/dsp_prod_next.sv
module dsp_prod_next
  import dsp_mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [2:0]       pn_op,
  input  logic [ACC_W-1:0] pn_prev,
  input  logic [ACC_W-1:0] pn_mul,
  output logic [ACC_W-1:0] pn_next
);
  always_comb begin
    unique case (pn_op)
      OP_MAC:  pn_next = pn_prev + pn_mul;
      OP_MACN: pn_next = pn_prev - pn_mul;
      OP_MPY, OP_MVMPY, OP_RNMPY, OP_ADMPY: pn_next = pn_mul;
      default: pn_next = pn_prev;
    endcase
  end
endmodule

// File: rtl/dsp_acc_alu.sv
module dsp_acc_alu
  import dsp_mac_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int RND_W = 16
) (
  input  logic [2:0]       alu_op,
  input  logic [ACC_W-1:0] alu_prod,
  input  logic [ACC_W-1:0] alu_acc,
  output logic [ACC_W-1:0] alu_res,
  output mac_flags_t       alu_flags,
  output logic             alu_wr
);
  localparam int EXT_LO = ACC_W - 9;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (RND_W - 1);
  localparam logic [ACC_W-1:0] LOW_MASK = (ACC_W'(1) << RND_W) - ACC_W'(1);

  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] rnd_term;
  logic [ACC_W:0]   sum_ext;
  logic [ACC_W-1:0] sum;
  logic             tie;
  logic             is_mv;

  always_comb begin
    is_mv    = (alu_op == OP_MVMPY);
    tie      = (alu_prod[RND_W-1:0] == HALF[RND_W-1:0]) && !alu_prod[RND_W];
    rnd_term = tie ? '0 : HALF;
    unique case (alu_op)
      OP_RNMPY: addend = rnd_term;
      OP_ADMPY: addend = alu_acc;
      default:  addend = '0;
    endcase
    sum_ext = {1'b0, alu_prod} + {1'b0, addend};
    sum     = sum_ext[ACC_W-1:0];
    alu_res = (alu_op == OP_RNMPY) ? (sum & ~LOW_MASK) : sum;
    alu_wr  = (alu_op == OP_MVMPY) || (alu_op == OP_RNMPY) || (alu_op == OP_ADMPY);

    alu_flags.c = is_mv ? 1'b0 : sum_ext[ACC_W];
    alu_flags.v = is_mv ? 1'b0 :
                  ((alu_prod[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != alu_prod[ACC_W-1]));
    alu_flags.z = (alu_res == '0);
    alu_flags.n = alu_res[ACC_W-1];
    alu_flags.e = !((&alu_res[ACC_W-1:EXT_LO]) || !(|alu_res[ACC_W-1:EXT_LO]));
    alu_flags.u = (alu_res[EXT_LO] == alu_res[EXT_LO-1]);
  end
endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
  import dsp_mac_pkg::*;
#(
  parameter int ACC_BITS  = dsp_mac_pkg::ACC_W,
  parameter int OPND_BITS = dsp_mac_pkg::OPND_W,
  parameter int RND_BITS  = dsp_mac_pkg::RND_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic                 op_dst,
  input  logic [OPND_BITS-1:0] opnd_x,
  input  logic [OPND_BITS-1:0] opnd_y,
  output logic [ACC_BITS-1:0]  acc_a,
  output logic [ACC_BITS-1:0]  acc_b,
  output logic [ACC_BITS-1:0]  prod,
  output logic                 flag_c,
  output logic                 flag_v,
  output logic                 flag_z,
  output logic                 flag_n,
  output logic                 flag_e,
  output logic                 flag_u
);
  logic                rst_q;
  logic [ACC_BITS-1:0] prod_q, prod_d, acc_a_q, acc_a_d, acc_b_q, acc_b_d;
  mac_flags_t          flags_q, flags_d;
  logic [ACC_BITS-1:0] mul_w, prod_nxt, acc_sel, alu_res;
  mac_flags_t          alu_flags;
  logic                alu_wr, legal, go;

  dsp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q)
  );

  dsp_mul #(.OPND_W(OPND_BITS), .ACC_W(ACC_BITS)) u_mul (
    .mul_x(opnd_x), .mul_y(opnd_y), .mul_p(mul_w)
  );

  dsp_prod_next #(.ACC_W(ACC_BITS)) u_pn (
    .pn_op(op_code), .pn_prev(prod_q), .pn_mul(mul_w), .pn_next(prod_nxt)
  );

  assign acc_sel = op_dst ? acc_b_q : acc_a_q;

  dsp_acc_alu #(.ACC_W(ACC_BITS), .RND_W(RND_BITS)) u_alu (
    .alu_op(op_code), .alu_prod(prod_q), .alu_acc(acc_sel),
    .alu_res(alu_res), .alu_flags(alu_flags), .alu_wr(alu_wr)
  );

  assign legal = (op_code <= OP_ADMPY);
  assign go    = op_valid && legal;

  always_comb begin
    prod_d  = prod_q;
    acc_a_d = acc_a_q;
    acc_b_d = acc_b_q;
    flags_d = flags_q;
    if (go) begin
      prod_d = prod_nxt;
      if (alu_wr) begin
        flags_d = alu_flags;
        if (op_dst) acc_b_d = alu_res;
        else        acc_a_d = alu_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prod_q  <= '0;
      acc_a_q <= '0;
      acc_b_q <= '0;
      flags_q <= '0;
    end else if (go) begin
      prod_q  <= prod_d;
      acc_a_q <= acc_a_d;
      acc_b_q <= acc_b_d;
      flags_q <= flags_d;
    end
  end

  assign prod   = prod_q;
  assign acc_a  = acc_a_q;
  assign acc_b  = acc_b_q;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_e = flags_q.e;
  assign flag_u = flags_q.u;

  p_idle_freeze_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !go |=> ($stable(prod_q) && $stable(acc_a_q) && $stable(acc_b_q) && $stable(flags_q)));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (go && (op_code == OP_MPY || op_code == OP_MAC || op_code == OP_MACN)) |=> $stable(flags_q));

  p_move_cv_clear_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (go && op_code == OP_MVMPY) |=> (!flag_c && !flag_v));

  p_round_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (go && op_code == OP_RNMPY) |=>
      (($past(op_dst) ? acc_b_q[RND_BITS-1:0] : acc_a_q[RND_BITS-1:0]) == '0));

  p_other_acc_kept_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (go && alu_wr) |=> ($past(op_dst) ? $stable(acc_a_q) : $stable(acc_b_q)));

  p_mac_sum_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (go && op_code == OP_MAC) |=> (prod_q == $past(prod_q) + $past(mul_w)));

  p_zero_neg_track_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (go && alu_wr) |=>
      (flag_z == (($past(op_dst) ? acc_b_q : acc_a_q) == '0)) &&
      (flag_n == ($past(op_dst) ? acc_b_q[ACC_BITS-1] : acc_a_q[ACC_BITS-1])));
endmodule

// File: tb/dsp_mac_unit_tb.sv
module dsp_mac_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic [2:0]  op;
    logic        dst;
    logic [15:0] x;
    logic [15:0] y;
    logic [39:0] pexp;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 16'd3,      16'd4,      40'd12},
    '{3'd1, 1'b0, 16'hFFFE,   16'd5,      40'd2},
    '{3'd2, 1'b0, 16'd7,      16'd1,      40'hFF_FFFF_FFFB},
    '{3'd3, 1'b0, 16'h0100,   16'h0100,   40'h00_0001_0000},
    '{3'd5, 1'b0, 16'd0,      16'd0,      40'd0},
    '{3'd4, 1'b1, 16'h7FFF,   16'h7FFF,   40'h00_3FFF_0001},
    '{3'd4, 1'b1, 16'h8000,   16'h8000,   40'h00_4000_0000},
    '{3'd3, 1'b1, 16'd0,      16'd0,      40'd0},
    '{3'd0, 1'b0, 16'd1,      16'hFFFF,   40'hFF_FFFF_FFFF},
    '{3'd2, 1'b0, 16'h8000,   16'h7FFF,   40'h00_3FFF_7FFF},
    '{3'd5, 1'b1, 16'd2,      16'd3,      40'd6}
  };

  logic        clk, rst_n, op_valid, op_dst;
  logic [2:0]  op_code;
  logic [15:0] opnd_x, opnd_y;
  logic [39:0] acc_a, acc_b, prod;
  logic        flag_c, flag_v, flag_z, flag_n, flag_e, flag_u;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [39:0] m_prod, m_a, m_b;
  logic [5:0]  m_f;

  dsp_mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .acc_a(acc_a), .acc_b(acc_b), .prod(prod),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n),
    .flag_e(flag_e), .flag_u(flag_u)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [39:0] act,
                       input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prod = '0; m_a = '0; m_b = '0; m_f = '0;
  endtask

  task automatic model_step(input logic [2:0] op, input logic dst,
                            input logic [15:0] x, input logic [15:0] y);
    longint      pl;
    logic [39:0] p, d, s, r;
    logic [40:0] se;
    logic        c, v;
    pl = longint'($signed(x)) * longint'($signed(y));
    p  = pl[39:0];
    d  = m_prod;
    s  = '0;
    if (op > 3'd5) return;
    if (op == 3'd4) s = (d[15:0] == 16'h8000 && !d[16]) ? 40'd0 : 40'h8000;
    if (op == 3'd5) s = dst ? m_b : m_a;
    se = {1'b0, d} + {1'b0, s};
    r  = se[39:0];
    if (op == 3'd4) r[15:0] = '0;
    c  = (op == 3'd3) ? 1'b0 : se[40];
    v  = (op == 3'd3) ? 1'b0 : (d[39] == s[39] && se[39] != d[39]);
    if (op >= 3'd3) begin
      if (dst) m_b = r; else m_a = r;
      m_f = {c, v, r == 40'd0, r[39],
             !((&r[39:31]) || !(|r[39:31])), r[31] == r[30]};
    end
    case (op)
      3'd1: m_prod = m_prod + p;
      3'd2: m_prod = m_prod - p;
      default: m_prod = p;
    endcase
  endtask

  task automatic compare_all(input string req_main, input string req_flag);
    check(req_main, "prod", prod, m_prod);
    check(req_main, "acc_a", acc_a, m_a);
    check(req_main, "acc_b", acc_b, m_b);
    check(req_flag, "flags", {34'd0, flag_c, flag_v, flag_z, flag_n, flag_e, flag_u},
          {34'd0, m_f});
  endtask

  task automatic run_op(input logic valid, input logic [2:0] op, input logic dst,
                        input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    op_valid = valid; op_code = op; op_dst = dst; opnd_x = x; opnd_y = y;
    if (valid) model_step(op, dst, x, y);
    @(posedge clk);
    #1;
    op_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    op_valid = 0; op_code = '0; op_dst = 0; opnd_x = '0; opnd_y = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    compare_all("R1", "R1");

    for (int i = 0; i < NV; i++) begin
      run_op(1'b1, TBL[i].op, TBL[i].dst, TBL[i].x, TBL[i].y);
      check(op_tag(TBL[i].op), "prod table", prod, TBL[i].pexp);
      compare_all(op_tag(TBL[i].op),
                  (TBL[i].op >= 3'd3) ? "R8" : "R9");
    end

    // R10: valid low, then illegal codes
    run_op(1'b0, 3'd0, 1'b0, 16'd9, 16'd9);
    compare_all("R10", "R10");
    run_op(1'b1, 3'd6, 1'b0, 16'd9, 16'd9);
    compare_all("R10", "R10");
    run_op(1'b1, 3'd7, 1'b1, 16'd9, 16'd9);
    compare_all("R10", "R10");

    // R6 tie with even bit 16: term is zero
    run_op(1'b1, 3'd0, 1'b0, 16'h0100, 16'h0080);
    run_op(1'b1, 3'd4, 1'b0, 16'd0, 16'd0);
    check("R6", "tie even acc_a", acc_a, 40'd0);
    check("R8", "tie even zero flag", {39'd0, flag_z}, 40'd1);
    check("R11", "acc_b untouched", acc_b, m_b);
    // R6 tie with odd bit 16: rounds up
    run_op(1'b1, 3'd0, 1'b0, 16'h0300, 16'h0080);
    run_op(1'b1, 3'd4, 1'b0, 16'd0, 16'd0);
    check("R6", "tie odd acc_a", acc_a, 40'h00_0002_0000);
    compare_all("R6", "R8");

    // R7 signed overflow: build 511 * 2^30, move to A, add 2^30
    run_op(1'b1, 3'd0, 1'b0, 16'h8000, 16'h8000);
    for (int k = 0; k < 510; k++) run_op(1'b1, 3'd1, 1'b0, 16'h8000, 16'h8000);
    check("R3", "long accumulate", prod, 40'h7F_C000_0000);
    run_op(1'b1, 3'd3, 1'b0, 16'h8000, 16'h8000);
    check("R5", "move carry", {39'd0, flag_c}, 40'd0);
    run_op(1'b1, 3'd5, 1'b0, 16'd0, 16'd0);
    check("R7", "overflow acc_a", acc_a, 40'h80_0000_0000);
    check("R7", "overflow flag", {39'd0, flag_v}, 40'd1);
    check("R7", "carry flag", {39'd0, flag_c}, 40'd0);
    compare_all("R7", "R8");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    compare_all("R1", "R1");
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all("R1", "R1");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule